// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers single-cycle event pulses from ten peripheral functions, for example loop detection, ring trip, power alarm, several timer expiries and completion of an indirect access. Each source owns one enable bit and one sticky status bit. A pulse sets its status bit only if the enable bit is already high. Once set, a status bit stays set until software clears it.

Software reaches the bits through a small register port: an address, a write strobe, write data and combinational read data. The ten status bits sit in three status registers and the ten enable bits sit in three enable registers. A status bit is cleared by writing 1 to its position. The interrupt line is active low, in the manner of an open-drain pin. It is low whenever any status bit is set.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, every register reads 0x00, and irq_n is 1.
- R2: Register layout. Source i occupies bit i%4 of register i/4. Status registers are at addresses 0, 1 and 2. Enable registers are at addresses 4, 5 and 6. Addresses 3 and 7 read 0x00, and writes to them change nothing. A write to an enable register loads its valid bits. Upper bits with no source always read 0.
- R3: A pulse on evt_i[i] while enable bit i is 1 sets status bit i on that clock edge.
- R4: A pulse on evt_i[i] while enable bit i is 0 leaves status bit i unchanged. The enable value used for an event is the one held before any write in the same cycle.
- R5: irq_n is 0 exactly when at least one status bit is 1.
- R6: Writing 1 to a status bit position clears that bit. Writing 0 leaves it unchanged. A write to an enable register leaves the status bits unchanged.
- R7: If an enabled event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R8: Clearing an enable bit does not clear a status bit that is already set.
- R9: A set status bit stays set until a clearing write reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Single-cycle event pulses, one per source |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Interrupt line, low while any status bit is set |

## Verification
The bench drives an event and a clearing write at the same bit in the same cycle. A design that lets the clear win would lose that interrupt. It also raises an enable in the same cycle as an event. A design that used the new enable would latch an event it should have ignored. It drops an enable after its status bit is set, to catch a design that wrongly clears status through the mask. It writes zeros to status registers and writes to unused addresses, to show that neither has any effect. It also checks that unused upper bits read 0 and that a source beyond the first register lands at the right bit.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Register that holds a given source
  function automatic int reg_index(input int src, input int per_reg);
    return src / per_reg;
  endfunction

  // Bit position of a given source inside its register
  function automatic int bit_index(input int src, input int per_reg);
    return src % per_reg;
  endfunction

  // Number of registers needed to hold all sources
  function automatic int reg_count(input int n_src, input int per_reg);
    return (n_src + per_reg - 1) / per_reg;
  endfunction
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int N_SRC       = 10,
  parameter int SRC_PER_REG = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [N_SRC-1:0]  clr_vec,
  output logic [N_SRC-1:0]  en_we_vec,
  output logic [N_SRC-1:0]  en_d_vec
);
  localparam int EN_BASE = 1 << (ADDR_W - 1);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int R = irq_ctrl_pkg::reg_index(i, SRC_PER_REG);
    localparam int B = irq_ctrl_pkg::bit_index(i, SRC_PER_REG);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(R);
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(EN_BASE + R);
    assign clr_vec[i]   = reg_we && (reg_addr == SA) && reg_wdata[B];
    assign en_we_vec[i] = reg_we && (reg_addr == EA);
    assign en_d_vec[i]  = reg_wdata[B];
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic [N_SRC-1:0] en_we_vec,
  input  logic [N_SRC-1:0] en_d_vec,
  output logic [N_SRC-1:0] en_vec,
  output logic [N_SRC-1:0] stat_vec,
  output logic [N_SRC-1:0] set_vec
);
  // Gate events with the enable held before this cycle's write
  assign set_vec = evt & en_vec;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_vec[i]   <= 1'b0;
        stat_vec[i] <= 1'b0;
      end else begin
        if (en_we_vec[i]) en_vec[i] <= en_d_vec[i];
        // Setting takes priority over clearing
        if (set_vec[i])      stat_vec[i] <= 1'b1;
        else if (clr_vec[i]) stat_vec[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int N_SRC       = 10,
  parameter int SRC_PER_REG = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]  stat_vec,
  input  logic [N_SRC-1:0]  en_vec,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int N_REG   = irq_ctrl_pkg::reg_count(N_SRC, SRC_PER_REG);
  localparam int EN_BASE = 1 << (ADDR_W - 1);

  logic [DATA_W-1:0] stat_word [N_REG];
  logic [DATA_W-1:0] en_word   [N_REG];

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int SRC = r * SRC_PER_REG + b;
      if (b < SRC_PER_REG && SRC < N_SRC) begin : g_used
        assign stat_word[r][b] = stat_vec[SRC];
        assign en_word[r][b]   = en_vec[SRC];
      end else begin : g_pad
        assign stat_word[r][b] = 1'b0;
        assign en_word[r][b]   = 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (reg_addr == ADDR_W'(r))           reg_rdata = stat_word[r];
      if (reg_addr == ADDR_W'(EN_BASE + r)) reg_rdata = en_word[r];
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int N_SRC       = 10,
  parameter int SRC_PER_REG = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  // Named internal events, visible to the bound checker
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] en_we_vec;
  logic [N_SRC-1:0] en_d_vec;
  logic [N_SRC-1:0] en_vec;
  logic [N_SRC-1:0] stat_vec;
  logic [N_SRC-1:0] set_vec;

  irq_addr_dec #(
    .N_SRC(N_SRC), .SRC_PER_REG(SRC_PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .clr_vec(clr_vec), .en_we_vec(en_we_vec), .en_d_vec(en_d_vec)
  );

  irq_status_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr_vec(clr_vec),
    .en_we_vec(en_we_vec), .en_d_vec(en_d_vec),
    .en_vec(en_vec), .stat_vec(stat_vec), .set_vec(set_vec)
  );

  irq_read_mux #(
    .N_SRC(N_SRC), .SRC_PER_REG(SRC_PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_mux (
    .reg_addr(reg_addr), .stat_vec(stat_vec), .en_vec(en_vec),
    .reg_rdata(reg_rdata)
  );

  // Line is pulled low while anything is pending
  assign irq_n = ~(|stat_vec);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_SRC = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt,
  input logic [N_SRC-1:0] en_vec,
  input logic [N_SRC-1:0] stat_vec,
  input logic [N_SRC-1:0] clr_vec,
  input logic             irq_n
);
  p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & en_vec) != '0) |=>
      ((stat_vec & $past(evt & en_vec)) == $past(evt & en_vec)));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & ~$past(stat_vec) & ~$past(evt & en_vec)) == '0));

  p_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == (stat_vec == '0));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~(evt & en_vec)) != '0) |=>
      ((stat_vec & $past(clr_vec & ~(evt & en_vec))) == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_vec & $past(stat_vec & ~clr_vec)) == '0));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt_i), .en_vec(en_vec),
  .stat_vec(stat_vec), .clr_vec(clr_vec), .irq_n(irq_n)
);

// File: tb/tb_irq_ctrl_top.sv
module tb_irq_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] evt_i = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] m_stat = '0;
  logic [9:0] m_en = '0;

  always #4 clk = ~clk;

  irq_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // Expected register value: four sources per register, enables from address 4
  function automatic logic [7:0] model_word(input logic [2:0] a);
    logic [7:0] w = '0;
    logic [9:0] src = a[2] ? m_en : m_stat;
    if (a[1:0] != 2'd3)
      for (int k = 0; k < 4; k++)
        if (int'(a[1:0]) * 4 + k < 10) w[k] = src[int'(a[1:0]) * 4 + k];
    return w;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [2:0] a);
    reg_addr = a;
    #1;
    check(req, reg_rdata, model_word(a));
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) check_reg(req, 3'(a));
    check({req, " irq_n"}, {7'd0, irq_n}, {7'd0, (m_stat == '0)});
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    check_all("R1");
  endtask

  task automatic t_layout;
    reg_write(3'd4, 8'hFF); reg_write(3'd5, 8'hFF); reg_write(3'd6, 8'hFF);
    m_en = 10'h3FF;
    check_reg("R2", 3'd4); check_reg("R2", 3'd5); check_reg("R2", 3'd6);
    check("R2 pad", reg_rdata, 8'h03);
    reg_write(3'd4, 8'hA5); m_en[3:0] = 4'h5;
    check_reg("R2", 3'd4);
    reg_write(3'd3, 8'hFF); reg_write(3'd7, 8'hFF);
    check_all("R2 unused");
    reg_write(3'd4, 8'h00); reg_write(3'd5, 8'h00); reg_write(3'd6, 8'h00);
    m_en = '0;
    check_all("R2");
  endtask

  task automatic t_masked;
    pulse(10'h3FF);
    check_all("R4");
  endtask

  task automatic t_enable_race;
    @(negedge clk);
    reg_addr = 3'd5; reg_wdata = 8'h0F; reg_we = 1'b1; evt_i = 10'h0F0;
    @(negedge clk);
    reg_we = 1'b0; evt_i = '0; m_en[7:4] = 4'hF;
    check_all("R4 same-cycle enable");
  endtask

  task automatic t_latch;
    reg_write(3'd4, 8'h0F); reg_write(3'd6, 8'h03); m_en = 10'h3FF;
    pulse(10'h200); m_stat[9] = 1'b1;
    check_all("R3");
    check("R5", {7'd0, irq_n}, 8'h00);
    repeat (5) @(negedge clk);
    check_all("R9");
    pulse(10'h021); m_stat |= 10'h021;
    check_all("R3 multi");
  endtask

  task automatic t_clear;
    reg_write(3'd2, 8'h00); check_all("R6 zero");
    reg_write(3'd4, 8'h0F); check_all("R6 enable write");
    reg_write(3'd0, 8'h01); m_stat[0] = 1'b0; check_all("R6 single");
    reg_write(3'd1, 8'h02); m_stat[5] = 1'b0; check_all("R6");
    reg_write(3'd2, 8'h02); m_stat[9] = 1'b0; check_all("R6 last");
    check("R5 idle", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_race;
    @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 8'h01; reg_we = 1'b1; evt_i = 10'h100;
    @(negedge clk);
    reg_we = 1'b0; evt_i = '0; m_stat[8] = 1'b1;
    check_all("R7");
  endtask

  task automatic t_mask_keep;
    reg_write(3'd6, 8'h00); m_en[9:8] = 2'b00;
    check_all("R8");
    pulse(10'h200);
    check_all("R8 masked");
    reg_write(3'd2, 8'h01); m_stat[8] = 1'b0;
    check_all("R6 after mask");
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_masked;
    t_enable_race;
    t_latch;
    t_clear;
    t_race;
    t_mask_keep;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule